// File: doc/BRIEF.md
# Converter Start-up and Fault Supervisor

This block sequences the start of a half-bridge power converter and stops it when a protection condition appears. It receives comparator flags that have already been synchronised to the clock. These are three supply levels (turn-on, minimum running, logic reset), a bulk-voltage brown-out OK flag, a latch request and an over-temperature flag. From them it produces three outputs: a run enable for the gate sequencer, a soft-start discharge command, and an enable for the current sink that gives the brown-out input its hysteresis.

All timing comes from a tick of fixed period, nominally 1 us, derived from the system clock by a prescaler. Start-up works as follows. The supply qualifies once it crosses the turn-on level and stays qualified down to the minimum level. The brown-out and latch inputs pass through glitch filters. Every restart then waits a fixed delay, nominally 100 ms, and the soft-start node is held discharged during that wait. After each supply restart the hysteresis sink is forced on for a one-shot window, nominally 50 ms.

A filtered latch request sets a permanent fault. Only two events clear it: the supply falling below the logic reset level, or the filtered brown-out flag going low.

Top module: `conv_start_supervisor`

## Requirements
- R1: Out of reset, run_en_o is 0, ss_dis_o is 1 and bo_sink_en_o is 1.
- R2: The supply is qualified when vcc_on_i is 1. It stays qualified while vcc_min_i is 1, even with vcc_on_i at 0. When vcc_min_i goes to 0 the supply is disqualified and run_en_o falls within 3 cycles.
- R3: run_en_o rises only after all run conditions have held without a break for START_TICKS ticks. ss_dis_o is 1 whenever run_en_o is 0.
- R4: bo_ok_i and latch_req_i act only after holding a new level for FILT_TICKS consecutive ticks. A shorter pulse has no effect on run_en_o.
- R5: bo_sink_en_o is 1 whenever the filtered brown-out flag is 0. Outside the one-shot window it is 0 when that flag is 1.
- R6: Each time the supply becomes qualified, bo_sink_en_o is forced to 1 for ONESHOT_TICKS ticks, even when brown-out is OK.
- R7: A filtered latch request sets a fault that holds run_en_o at 0. The fault stays set after latch_req_i returns to 0.
- R8: vcc_rst_i at 0 clears all state, including the fault, as a reset does. A filtered brown-out flag at 0 also clears the fault.
- R9: ot_i at 1 drops run_en_o on the next clock edge. When ot_i clears, the converter restarts through the full start delay.
- R10: If any run condition is lost while the start delay is counting, the delay is abandoned. The next attempt counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vcc_on_i | input | 1 | Supply above turn-on level |
| vcc_min_i | input | 1 | Supply above minimum running level |
| vcc_rst_i | input | 1 | Supply above logic reset level |
| bo_ok_i | input | 1 | Bulk voltage above brown-out threshold |
| latch_req_i | input | 1 | Request for permanent shutdown |
| ot_i | input | 1 | Over-temperature flag (hysteresis applied upstream) |
| run_en_o | output | 1 | Run enable to the gate sequencer |
| ss_dis_o | output | 1 | Soft-start discharge command |
| bo_sink_en_o | output | 1 | Brown-out hysteresis current sink enable |

## Verification
The assertions check on every cycle the following: a thermal flag or a set fault stops the run enable on the next edge; the run enable rises only on completion of the start timer; the sink is never off while the filtered brown-out flag is low; the filtered flag rises only after the raw input was high; and a supply drop below the reset level clears the fault. The bench scenarios cover the behaviour that only a sequence in time can show. These are the length of the start delay, the sink one-shot after a restart, glitch rejection against real filter expiry, the latch surviving its release, the two routes that clear it, and a delay restarted from zero after an abort.

// File: rtl/sup_pkg.sv
// Package: shared types for the start-up supervisor.
package sup_pkg;
    // Sequencer states: stopped, counting the start delay, running.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } sup_state_e;
endpackage

// File: rtl/sup_tick_gen.sv
// Tick prescaler: emits a one-cycle tick every DIV clocks.
// Assumes DIV >= 1; with DIV == 1 the tick is permanently high.
module sup_tick_gen #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV == 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;
            // Free-running divider counter.
            always_ff @(posedge clk) begin
                if (!rst_n)                  cnt <= '0;
                else if (cnt == CW'(DIV-1))  cnt <= '0;
                else                         cnt <= cnt + CW'(1);
            end
            assign tick = (cnt == CW'(DIV-1));
        end
    endgenerate
endmodule

// File: rtl/sup_filter.sv
// Glitch filter: the output takes the input level only after the input
// has differed from it for TICKS consecutive ticks. Any return to the
// current output level restarts the count. clr forces output low.
module sup_filter #(
    parameter int TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic din,
    output logic dout
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    logic [CW-1:0] cnt;

    // Count ticks of disagreement; commit the new level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            dout <= 1'b0;
            cnt  <= '0;
        end else if (din == dout) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == CW'(TICKS-1)) begin
                dout <= din;
                cnt  <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/sup_interval.sv
// Tick interval timer: start begins a window of TICKS ticks, busy is high
// during it and done pulses for one cycle when it ends. clr aborts.
module sup_interval #(
    parameter int TICKS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    input  logic tick,
    output logic busy,
    output logic done
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    logic [CW-1:0] cnt;

    // Window counter with abort, restart and end-of-window pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            done <= 1'b0;
            cnt  <= '0;
        end else if (busy && tick) begin
            if (cnt == CW'(TICKS-1)) begin
                busy <= 1'b0;
                done <= 1'b1;
                cnt  <= '0;
            end else begin
                done <= 1'b0;
                cnt  <= cnt + CW'(1);
            end
        end else begin
            done <= 1'b0;
        end
    end
endmodule

// File: rtl/conv_start_supervisor.sv
// Start-up and fault supervisor for a half-bridge converter.
// Assumes all flag inputs are already synchronised to clk. Timers count
// ticks of CLK_PER_TICK clocks. A low vcc_rst_i acts as a full logic clear.
module conv_start_supervisor
    import sup_pkg::*;
#(
    parameter int CLK_PER_TICK  = 100,
    parameter int START_TICKS   = 100000,
    parameter int ONESHOT_TICKS = 50000,
    parameter int FILT_TICKS    = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_on_i,
    input  logic vcc_min_i,
    input  logic vcc_rst_i,
    input  logic bo_ok_i,
    input  logic latch_req_i,
    input  logic ot_i,
    output logic run_en_o,
    output logic ss_dis_o,
    output logic bo_sink_en_o
);
    localparam int NFILT = 2;

    logic             tick;
    logic             clr;
    logic             supply_q, supply_nxt, supply_rise;
    logic [NFILT-1:0] filt_in, filt_out;
    logic             bo_filt, lat_filt;
    logic             fault_q;
    logic             run_ok;
    logic             dly_start, dly_clr, dly_busy, dly_done;
    logic             os_busy, os_done;
    sup_state_e       state_q;

    assign clr = !vcc_rst_i;

    sup_tick_gen #(.DIV(CLK_PER_TICK)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    // Brown-out and latch filters share one structure.
    assign filt_in = {latch_req_i, bo_ok_i};
    generate
        for (genvar i = 0; i < NFILT; i++) begin : g_filt
            sup_filter #(.TICKS(FILT_TICKS)) u_f (
                .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
                .din(filt_in[i]), .dout(filt_out[i])
            );
        end
    endgenerate
    assign bo_filt  = filt_out[0];
    assign lat_filt = filt_out[1];

    // Supply hysteresis: qualify on turn-on level, drop below minimum.
    always_comb begin
        supply_nxt = supply_q;
        if (vcc_on_i)        supply_nxt = 1'b1;
        else if (!vcc_min_i) supply_nxt = 1'b0;
    end
    assign supply_rise = supply_nxt && !supply_q;

    // Supply qualification register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) supply_q <= 1'b0;
        else               supply_q <= supply_nxt;
    end

    // Permanent fault latch; a brown-out drop clears it before any set.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  fault_q <= 1'b0;
        else if (!bo_filt)  fault_q <= 1'b0;
        else if (lat_filt)  fault_q <= 1'b1;
    end

    assign run_ok = supply_q && bo_filt && !fault_q && !ot_i;

    // Forced hysteresis-sink window after each supply restart.
    sup_interval #(.TICKS(ONESHOT_TICKS)) u_oneshot (
        .clk(clk), .rst_n(rst_n), .clr(clr), .start(supply_rise),
        .tick(tick), .busy(os_busy), .done(os_done)
    );

    // Start delay timer, aborted whenever a run condition is lost.
    assign dly_start = (state_q == ST_IDLE) && run_ok;
    assign dly_clr   = clr || !run_ok;
    sup_interval #(.TICKS(START_TICKS)) u_delay (
        .clk(clk), .rst_n(rst_n), .clr(dly_clr), .start(dly_start),
        .tick(tick), .busy(dly_busy), .done(dly_done)
    );

    // Sequencer: idle -> delay -> run, back to idle on any loss.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (run_ok) state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (!run_ok)       state_q <= ST_IDLE;
                    else if (dly_done) state_q <= ST_RUN;
                end
                ST_RUN:  if (!run_ok) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign run_en_o     = (state_q == ST_RUN);
    assign ss_dis_o     = (state_q != ST_RUN);
    assign bo_sink_en_o = os_busy || !bo_filt;

    // The end-of-window pulse and busy flag of the delay are not needed here.
    logic unused_ok;
    assign unused_ok = &{1'b0, os_done, dly_busy};
endmodule

// File: rtl/sup_checker.sv
// Property checker for the start-up supervisor, bound to every instance.
module sup_checker
    import sup_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       vcc_rst_i,
    input logic       bo_ok_i,
    input logic       ot_i,
    input logic       run_en_o,
    input logic       bo_sink_en_o,
    input logic       bo_filt,
    input logic       fault_q,
    input logic       dly_done
);
    // R9: thermal flag stops the run enable on the next edge.
    assert_ot_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en_o && ot_i) |=> !run_en_o);

    // R7: a set fault never lets the converter run.
    assert_fault_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q |=> !run_en_o);

    // R3: running starts only when the start timer completes.
    assert_run_after_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en_o) |-> $past(dly_done));

    // R5: sink is never off while brown-out is not OK.
    assert_sink_on_low_bo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bo_sink_en_o |-> bo_filt);

    // R4: filtered flag rises only after the raw input was high.
    assert_filter_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bo_filt) |-> $past(bo_ok_i));

    // R8: supply below reset level clears the fault and the run enable.
    assert_deep_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_rst_i |=> (!fault_q && !run_en_o));
endmodule

bind conv_start_supervisor sup_checker u_sup_checker (
    .clk(clk), .rst_n(rst_n), .vcc_rst_i(vcc_rst_i), .bo_ok_i(bo_ok_i),
    .ot_i(ot_i), .run_en_o(run_en_o), .bo_sink_en_o(bo_sink_en_o),
    .bo_filt(bo_filt), .fault_q(fault_q), .dly_done(dly_done)
);

// File: tb/tb_conv_start_supervisor.sv
// Scoreboard bench: driver pushes expected output values, monitor compares.
module tb_conv_start_supervisor;
    localparam int DIV = 4;
    localparam int ST  = 50;   // 200 cycles
    localparam int OS  = 20;   // 80 cycles
    localparam int FT  = 4;    // 16 cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_on = 1'b0, vcc_min = 1'b0, vcc_rst = 1'b0;
    logic bo_ok = 1'b0, latch_req = 1'b0, ot = 1'b0;
    logic run_en, ss_dis, sink_en;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        int    sel;   // 0 run_en, 1 ss_dis, 2 sink_en
        logic  val;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    conv_start_supervisor #(
        .CLK_PER_TICK(DIV), .START_TICKS(ST),
        .ONESHOT_TICKS(OS), .FILT_TICKS(FT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .vcc_on_i(vcc_on), .vcc_min_i(vcc_min),
        .vcc_rst_i(vcc_rst), .bo_ok_i(bo_ok), .latch_req_i(latch_req),
        .ot_i(ot), .run_en_o(run_en), .ss_dis_o(ss_dis),
        .bo_sink_en_o(sink_en)
    );

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_sig(input int sel, input logic val, input string tag);
        exp_t e;
        e.sel = sel; e.val = val; e.tag = tag;
        sb.push_back(e);
        wait_cyc(1);
    endtask

    // Monitor: pops expected items and compares them away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                logic act;
                e = sb.pop_front();
                act = (e.sel == 0) ? run_en : (e.sel == 1) ? ss_dis : sink_en;
                total++;
                if (act !== e.val) begin
                    bad++;
                    $display("FAIL %s sel=%0d actual=%b expected=%b", e.tag, e.sel, act, e.val);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        wait_cyc(150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        // R1 reset state
        expect_sig(0, 1'b0, "R1 run after reset");
        expect_sig(1, 1'b1, "R1 discharge after reset");
        expect_sig(2, 1'b1, "R1 sink after reset");
        rst_n = 1'b1;
        wait_cyc(2);

        // Power up: R6 one-shot, R3 delay
        vcc_rst = 1; vcc_min = 1; vcc_on = 1; bo_ok = 1;
        wait_cyc(50);
        expect_sig(2, 1'b1, "R6 sink forced in one-shot");
        wait_cyc(70);
        expect_sig(2, 1'b0, "R5 sink off after one-shot");
        wait_cyc(60);
        expect_sig(0, 1'b0, "R3 run before delay ends");
        wait_cyc(80);
        expect_sig(0, 1'b1, "R3 run after delay");
        expect_sig(1, 1'b0, "R3 discharge off while running");

        // R2 hysteresis
        vcc_on = 0;
        wait_cyc(40);
        expect_sig(0, 1'b1, "R2 run holds above minimum");
        vcc_min = 0;
        wait_cyc(3);
        expect_sig(0, 1'b0, "R2 run off below minimum");
        expect_sig(1, 1'b1, "R3 discharge when stopped");

        // Restart through supply
        vcc_min = 1; vcc_on = 1;
        wait_cyc(40);
        expect_sig(2, 1'b1, "R6 one-shot on restart");
        wait_cyc(140);
        expect_sig(0, 1'b0, "R3 restart still delaying");
        wait_cyc(70);
        expect_sig(0, 1'b1, "R3 run after restart delay");

        // R4 brown-out glitch ignored
        bo_ok = 0; wait_cyc(8); bo_ok = 1;
        wait_cyc(40);
        expect_sig(0, 1'b1, "R4 short brown-out ignored");
        expect_sig(2, 1'b0, "R4 sink stays off after glitch");

        // Real brown-out
        bo_ok = 0;
        wait_cyc(30);
        expect_sig(0, 1'b0, "R4 brown-out stops run");
        expect_sig(2, 1'b1, "R5 sink on in brown-out");
        bo_ok = 1;
        wait_cyc(40);
        expect_sig(2, 1'b0, "R5 sink off when brown-out OK");
        wait_cyc(140);
        expect_sig(0, 1'b0, "R3 delay after brown-out");
        wait_cyc(80);
        expect_sig(0, 1'b1, "R3 run after brown-out delay");

        // R7 latch
        latch_req = 1; wait_cyc(8); latch_req = 0;
        wait_cyc(40);
        expect_sig(0, 1'b1, "R4 short latch request ignored");
        latch_req = 1;
        wait_cyc(40);
        expect_sig(0, 1'b0, "R7 latch stops run");
        latch_req = 0;
        wait_cyc(300);
        expect_sig(0, 1'b0, "R7 latch holds after release");
        // R8 clear by brown-out
        bo_ok = 0; wait_cyc(40); bo_ok = 1;
        wait_cyc(260);
        expect_sig(0, 1'b1, "R8 latch cleared by brown-out");

        // R8 clear by deep supply loss
        latch_req = 1; wait_cyc(40); latch_req = 0;
        expect_sig(0, 1'b0, "R7 latch set again");
        vcc_rst = 0; vcc_min = 0; vcc_on = 0;
        wait_cyc(10);
        expect_sig(2, 1'b1, "R8 sink on after deep clear");
        vcc_rst = 1; vcc_min = 1; vcc_on = 1;
        wait_cyc(300);
        expect_sig(0, 1'b1, "R8 latch cleared by supply reset");

        // R9 thermal
        ot = 1;
        wait_cyc(2);
        expect_sig(0, 1'b0, "R9 thermal stops run");
        expect_sig(1, 1'b1, "R9 discharge on thermal stop");
        ot = 0;
        wait_cyc(180);
        expect_sig(0, 1'b0, "R9 full delay after thermal");
        wait_cyc(70);
        expect_sig(0, 1'b1, "R9 run after thermal delay");

        // R10 abort during delay
        ot = 1; wait_cyc(3); ot = 0;
        wait_cyc(100);
        ot = 1; wait_cyc(2); ot = 0;
        wait_cyc(160);
        expect_sig(0, 1'b0, "R10 delay restarted from zero");
        wait_cyc(90);
        expect_sig(0, 1'b1, "R10 run after restarted delay");

        wait_cyc(4);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule